// File: doc/BRIEF.md
# Row-Miss Deferral Gate

This unit sits between a DRAM transaction scheduler and its command issue stage. When the scheduler's current candidate is a row miss, the missed bank must precharge and then activate before it can return data. Issuing the miss at once leaves the data bus idle for that whole time. The gate holds the miss back until enough column commands that hit open rows in other banks have gone out. Those commands keep the bus busy while the missed bank opens its new row.

The number of hits the gate waits for comes from a small read-only table. The table is indexed by how many banks other than the candidate's bank currently have row hits pending. Each entry is `ceil(SLOTS / n)`, where SLOTS is the number of hit slots needed to cover read-to-precharge, precharge and activate-to-read. With more banks able to supply hits, fewer hits are needed before the miss goes. If no other bank has a hit pending, waiting cannot help, so the miss is released at once. Row-hit candidates are never held.

A counter counts the hits issued to other banks while the current candidate is waiting. It clears when a new candidate is presented and when the current one issues. The output `permit` is registered: it reflects the inputs and the counter in the cycle before.

Top module: `miss_defer_gate`

## Requirements
- R1: While `rst` is high, `permit` is 0 on the following cycle and the hit count returns to zero.
- R2: A valid candidate with `cand_is_miss`=0 that does not issue in that cycle gives `permit`=1 on the next cycle.
- R3: With `cand_valid`=0, `permit` is 0 on the next cycle.
- R4: A missing candidate is permitted only once the row hits issued to other banks since it became the candidate reach `ceil(12 / n)`. Here n is the count of set bits in `pend_hit_vec` (bit i = bank i) other than bit `cand_bank`, with the default SLOTS=12 and 16 banks.
- R5: A `hit_issued` pulse whose `hit_bank` equals `cand_bank` does not advance the count.
- R6: The candidate's own bit in `pend_hit_vec` is left out of n.
- R7: When n is 0, a missing candidate is permitted on the next cycle without waiting.
- R8: A `cand_new` pulse clears the count in the same cycle, so the new candidate waits the full number of hits.
- R9: A `cand_issued` pulse clears the count and gives `permit`=0 on the next cycle.
- R10: The count saturates at SLOTS and never wraps. Once permitted, a miss stays permitted while further hits arrive.
- R11: The required number is looked up again every cycle from the current `pend_hit_vec`. A growing n can release a waiting miss without further hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate request is presented |
| cand_new | input | 1 | First cycle of a newly presented candidate |
| cand_is_miss | input | 1 | Candidate targets a closed row (1) or an open row (0) |
| cand_bank | input | BANK_W (4) | Bank of the candidate |
| cand_issued | input | 1 | The candidate is issued this cycle |
| pend_hit_vec | input | NUM_BANKS (16) | Bit i set when bank i has a pending row hit |
| hit_issued | input | 1 | A row-hit column command is issued this cycle |
| hit_bank | input | BANK_W (4) | Bank of the issued row hit |
| permit | output | 1 | Registered permission to issue the candidate |

## Verification
The properties assume that `cand_new` and `cand_issued` are only raised together with `cand_valid`. They also assume that a hit pulse never arrives in the cycle that presents a new candidate. The directed tasks raise `cand_new` for exactly one cycle with the candidate valid, pulse `cand_issued` only after `permit` is seen, and start hit pulses one cycle after the new candidate. Bank numbers and the pending vector stay steady inside a scenario, except where a scenario changes them on purpose to test the lookup.

// File: rtl/miss_defer_pkg.sv
package miss_defer_pkg;

  // Hits to other banks needed to cover the gap before a missed bank can return
  // data. Zero contributors maps to the full slot count; the top releases that
  // case directly.
  function automatic int unsigned burst_len(input int unsigned others,
                                            input int unsigned slots);
    if (others == 0) return slots;
    return (slots + others - 1) / others;
  endfunction

endpackage

// File: rtl/other_bank_count.sv
module other_bank_count #(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int POP_W   = $clog2(NUM_BANKS + 1)
) (
  input  logic [NUM_BANKS-1:0] vec,
  input  logic [BANK_W-1:0]    own_bank,
  output logic [POP_W-1:0]     others
);

  logic [NUM_BANKS-1:0] masked;

  always_comb begin
    masked = vec;
    masked[own_bank] = 1'b0;
    others = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      others = others + POP_W'(masked[i]);
    end
  end

endmodule

// File: rtl/burst_rom.sv
module burst_rom #(
  parameter int NUM_BANKS = 16,
  parameter int SLOTS     = 12,
  localparam int POP_W    = $clog2(NUM_BANKS + 1),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic [POP_W-1:0] addr,
  output logic [CNT_W-1:0] need
);
  import miss_defer_pkg::*;

  localparam int DEPTH = NUM_BANKS + 1;

  logic [CNT_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = CNT_W'(burst_len(g, SLOTS));
  end

  assign need = (int'(addr) < DEPTH) ? rom[addr] : CNT_W'(SLOTS);

endmodule

// File: rtl/hit_counter.sv
module hit_counter #(
  parameter int NUM_BANKS = 16,
  parameter int SLOTS     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              track,
  input  logic              hit_issued,
  input  logic [BANK_W-1:0] hit_bank,
  input  logic [BANK_W-1:0] own_bank,
  output logic [CNT_W-1:0]  cnt_next,
  output logic [CNT_W-1:0]  cnt
);

  logic counts;

  assign counts = track && hit_issued && (hit_bank != own_bank);

  always_comb begin
    if (clear)
      cnt_next = '0;
    else if (counts && (cnt != CNT_W'(SLOTS)))
      cnt_next = cnt + 1'b1;
    else
      cnt_next = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_next;
  end

endmodule

// File: rtl/miss_defer_gate.sv
module miss_defer_gate #(
  parameter int NUM_BANKS = 16,
  parameter int SLOTS     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int POP_W    = $clog2(NUM_BANKS + 1),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cand_valid,
  input  logic                 cand_new,
  input  logic                 cand_is_miss,
  input  logic [BANK_W-1:0]    cand_bank,
  input  logic                 cand_issued,
  input  logic [NUM_BANKS-1:0] pend_hit_vec,
  input  logic                 hit_issued,
  input  logic [BANK_W-1:0]    hit_bank,
  output logic                 permit
);

  logic [POP_W-1:0] others;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] hit_cnt;
  logic             release_ok;

  other_bank_count #(.NUM_BANKS(NUM_BANKS)) u_count (
    .vec      (pend_hit_vec),
    .own_bank (cand_bank),
    .others   (others)
  );

  burst_rom #(.NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS)) u_rom (
    .addr (others),
    .need (need)
  );

  hit_counter #(.NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clear      (cand_new || cand_issued),
    .track      (cand_valid && cand_is_miss),
    .hit_issued (hit_issued),
    .hit_bank   (hit_bank),
    .own_bank   (cand_bank),
    .cnt_next   (cnt_next),
    .cnt        (hit_cnt)
  );

  assign release_ok = !cand_is_miss || (others == '0) || (cnt_next >= need);

  always_ff @(posedge clk) begin
    if (rst) permit <= 1'b0;
    else     permit <= cand_valid && !cand_issued && release_ok;
  end

endmodule

// File: rtl/miss_defer_gate_chk.sv
module miss_defer_gate_chk #(
  parameter int NUM_BANKS = 16,
  parameter int SLOTS     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cand_valid,
  input logic                 cand_new,
  input logic                 cand_is_miss,
  input logic [BANK_W-1:0]    cand_bank,
  input logic                 cand_issued,
  input logic [NUM_BANKS-1:0] pend_hit_vec,
  input logic                 permit,
  input logic [CNT_W-1:0]     cnt
);

  logic [NUM_BANKS-1:0] own_bit;
  assign own_bit = {{(NUM_BANKS-1){1'b0}}, 1'b1} << cand_bank;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!permit && cnt == '0));

  p_hit_passes_r2: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !cand_is_miss && !cand_issued) |=> permit);

  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |=> !permit);

  p_lone_miss_r7: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !cand_issued && $countones(pend_hit_vec & ~own_bit) == 0) |=> permit);

  p_new_clears_r8: assert property (@(posedge clk) disable iff (rst)
    cand_new |=> (cnt == '0));

  p_issue_drops_r9: assert property (@(posedge clk) disable iff (rst)
    cand_issued |=> (!permit && cnt == '0));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (!cand_new && !cand_issued && cnt == CNT_W'(SLOTS)) |=> (cnt == CNT_W'(SLOTS)));

endmodule

bind miss_defer_gate miss_defer_gate_chk #(.NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cand_valid   (cand_valid),
  .cand_new     (cand_new),
  .cand_is_miss (cand_is_miss),
  .cand_bank    (cand_bank),
  .cand_issued  (cand_issued),
  .pend_hit_vec (pend_hit_vec),
  .permit       (permit),
  .cnt          (hit_cnt)
);

// File: tb/miss_defer_gate_tb_top.sv
module miss_defer_gate_tb_top;

  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        cand_valid, cand_new, cand_is_miss, cand_issued, hit_issued;
  logic [3:0]  cand_bank, hit_bank;
  logic [NB-1:0] pend_hit_vec;
  logic        permit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  miss_defer_gate dut_i (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_new(cand_new),
    .cand_is_miss(cand_is_miss), .cand_bank(cand_bank), .cand_issued(cand_issued),
    .pend_hit_vec(pend_hit_vec), .hit_issued(hit_issued), .hit_bank(hit_bank),
    .permit(permit)
  );

  function automatic int need_of(input int n);
    return (12 + n - 1) / n;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp);
    total++;
    if (permit !== exp) begin
      bad++;
      $display("FAIL %s: permit=%b expected=%b", req, permit, exp);
    end
  endtask

  task automatic quiet();
    cand_valid = 0; cand_new = 0; cand_is_miss = 0; cand_issued = 0;
    hit_issued = 0; cand_bank = 0; hit_bank = 0; pend_hit_vec = '0;
  endtask

  task automatic present(input logic miss, input logic [3:0] bank, input logic [NB-1:0] vec);
    cand_valid = 1; cand_new = 1; cand_is_miss = miss; cand_bank = bank;
    pend_hit_vec = vec;
    step();
    cand_new = 0;
  endtask

  task automatic hits(input int n, input logic [3:0] bank, input string req, input logic exp);
    for (int i = 0; i < n; i++) begin
      hit_issued = 1; hit_bank = bank;
      step();
      hit_issued = 0;
      check(req, exp);
    end
  endtask

  task automatic t_reset();
    quiet(); rst = 1;
    cand_valid = 1;
    step(); step();
    check("R1", 0);
    rst = 0; quiet(); step();
  endtask

  task automatic t_plain_hit();
    present(0, 4'd3, 16'h0000);
    check("R2", 1);
    quiet(); step();
    check("R3", 0);
  endtask

  task automatic t_wait_burst();
    present(1, 4'd0, 16'h0006);
    check("R4", 0);
    hits(need_of(2) - 1, 4'd3, "R4", 0);
    hits(1, 4'd3, "R4", 1);
    quiet(); step();
  endtask

  task automatic t_own_bank_hits();
    present(1, 4'd4, 16'h00F0);
    hits(need_of(3), 4'd4, "R5", 0);
    hits(need_of(3) - 1, 4'd5, "R5", 0);
    hits(1, 4'd5, "R5", 1);
    quiet(); step();
  endtask

  task automatic t_own_bit_excluded();
    present(1, 4'd2, 16'h000C);
    hits(6, 4'd7, "R6", 0);
    hits(5, 4'd7, "R6", 0);
    hits(1, 4'd7, "R6", 1);
    hits(6, 4'd7, "R10", 1);
    quiet(); step();
  endtask

  task automatic t_lone_miss();
    present(1, 4'd9, 16'h0200);
    check("R7", 1);
    quiet(); step();
  endtask

  task automatic t_new_clears();
    present(1, 4'd1, 16'h0030);
    hits(5, 4'd4, "R8", 0);
    present(1, 4'd1, 16'h0030);
    check("R8", 0);
    hits(5, 4'd4, "R8", 0);
    hits(1, 4'd4, "R8", 1);
    cand_issued = 1;
    step();
    cand_issued = 0;
    check("R9", 0);
    step();
    check("R9", 0);
    quiet(); step();
  endtask

  task automatic t_grow_lookup();
    present(1, 4'd0, 16'h0006);
    hits(2, 4'd1, "R11", 0);
    pend_hit_vec = 16'h007E;
    step();
    check("R11", 1);
    quiet(); step();
  endtask

  initial begin
    quiet(); rst = 1;
    t_reset();
    t_plain_hit();
    t_wait_burst();
    t_own_bank_hits();
    t_own_bit_excluded();
    t_lone_miss();
    t_new_clears();
    t_grow_lookup();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule